// File: doc/BRIEF.md
# Duty-Cycled Temperature Conversion Sequencer

This block decides when an external temperature converter runs. Two mode bits choose between a powered-down state, a single on-demand measurement and a repeating measurement loop. Two rate bits choose how often the loop repeats. Each conversion begins with a one-cycle start pulse and ends when the converter returns a done pulse with an 8-bit two's-complement result. The block stores that result as the current temperature.

In the repeating loop the block sleeps between conversions. The sleep counts ticks of a millisecond timebase, starting from the done pulse. The sleep length is the rate period minus the nominal conversion time; both are parameters. The mode bits it returns are the live ones, so a single measurement reads back as running until it completes and then as powered down. A mode change never cuts off a conversion that is already under way.

Top module: `tsq_conv_sequencer`

## Requirements
- R1: During reset the temperature reads 0x00 and the mode reads 2'b10 (repeating loop), with rate 2'b00. On the first clock edge after reset is released the sequencer leaves its reset state, and `conv_start` is high in the following cycle.
- R2: `conv_start` is high for exactly one cycle. No further start is issued until the converter's done pulse for the current conversion has been taken.
- R3: A done pulse during a conversion loads `conv_result` into `temp_q` on that clock edge. `temp_q` changes at no other time, and a done pulse while no conversion is pending leaves `temp_q` unchanged.
- R4: In the repeating loop (mode bit 1 set) the block counts D ticks of `ms_tick` after each done pulse and then issues the next start at the next clock. D is 3974, 974, 224 and 99 for rate codes 00, 01, 10 and 11: periods of 4000, 1000, 250 and 125 ms, less 26 ms of conversion.
- R5: A rate write does not change the sleep already being counted. It sets the length of the next sleep, which is loaded at the next done pulse.
- R6: Writing mode 2'b01 while the mode is 2'b00 and no conversion is pending issues one start at once. The mode reads 2'b01 until that conversion's done pulse, then 2'b00, and no further start follows.
- R7: A write of mode 2'b01 is ignored unless the mode is 2'b00 and no conversion is pending. The mode bits are left unchanged and no start is issued.
- R8: Writing mode 2'b00 during a conversion makes the mode read 2'b00 at once. The conversion still completes and its result is loaded, and no later start is issued.
- R9: Writing mode 2'b00 during a sleep ends the loop, so no later start is issued. Writing mode 2'b10 or 2'b11 while powered down and idle issues a start at once.
- R10: Writing mode 2'b10 or 2'b11 during a single measurement lets that conversion finish. The mode keeps the written value, and after the done pulse the block sleeps for the delay chosen by the rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up or bus-wide reset command) |
| ms_tick | input | 1 | One-cycle pulse per millisecond from the timebase |
| cfg_wr | input | 1 | Write strobe for the mode and rate fields |
| cfg_mode | input | 2 | Mode value to write: 00 off, 01 single, 1x repeating |
| cfg_rate | input | 2 | Rate code to write: 00 slowest to 11 fastest |
| mode_rd | output | 2 | Live mode bits for readback |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 8 | Converter result, valid with `conv_done` |
| temp_q | output | 8 | Most recent temperature result |

## Verification
The assertions check, on every cycle, that a start lasts one cycle and that a pending conversion is never left without its done pulse. They also check that the temperature moves only on an accepted done pulse, that a single measurement reverts to powered down, that a rejected single-measurement write leaves the mode intact, and that a powered-down idle sequencer stays quiet. Only the bench scenarios show the exact sleep lengths for each rate code. The same holds for a rate change landing in the following interval rather than the current one, for a shutdown written during a conversion or a sleep, and for an upgrade from single to repeating mode. A behavioural model compared on every clock covers irregular tick spacing.

// File: rtl/tsq_pkg.sv
// Shared types and field codes for the conversion sequencer.
// Assumes 2-bit mode and 2-bit rate fields as seen by the register file.
package tsq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LAUNCH = 2'd1,
        PH_CONV   = 2'd2,
        PH_SLEEP  = 2'd3
    } tsq_phase_e;

    localparam logic [1:0] MODE_OFF     = 2'b00;
    localparam logic [1:0] MODE_SINGLE  = 2'b01;
    localparam logic [1:0] MODE_RUN_RST = 2'b10;
    localparam logic [1:0] RATE_RST     = 2'b00;
endpackage

// File: rtl/tsq_mode_reg.sv
// Holds the live mode bits and the rate code. Applies the write rules:
// a single-measurement request is only taken when powered down and idle,
// and a single measurement falls back to off when its conversion ends.
// Assumes conv_end is a one-cycle pulse marking an accepted done.
module tsq_mode_reg
    import tsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic [1:0] wr_rate,
    input  logic       idle_now,
    input  logic       conv_end,
    output logic [1:0] mode_q,
    output logic [1:0] mode_d,
    output logic [1:0] rate_q
);
    logic single_ok;

    assign single_ok = (mode_q == MODE_OFF) && idle_now;

    // Next mode: apply the write, then the automatic fall-back of a single run.
    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            if (wr_mode == MODE_SINGLE) begin
                if (single_ok) mode_d = MODE_SINGLE;
            end else begin
                mode_d = wr_mode;
            end
        end
        if (conv_end && (mode_d == MODE_SINGLE)) mode_d = MODE_OFF;
    end

    // Register the mode and rate fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN_RST;
            rate_q <= RATE_RST;
        end else begin
            mode_q <= mode_d;
            if (wr_en) rate_q <= wr_rate;
        end
    end

    p_single_revert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SINGLE && conv_end && !wr_en) |=> (mode_q == MODE_OFF));

    p_single_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == MODE_SINGLE && mode_q != MODE_OFF && !conv_end)
        |=> (mode_q == $past(mode_q)));

    p_rate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rate_q));
endmodule

// File: rtl/tsq_sleep_timer.sv
// Counts the sleep between repeating conversions in timebase ticks.
// The length is picked from the rate code at the moment of loading, so a
// later rate change affects only the next interval. expired is high when
// the count is exhausted. Assumes every period exceeds CONV_MS.
module tsq_sleep_timer #(
    parameter int P0_MS   = 4000,
    parameter int P1_MS   = 1000,
    parameter int P2_MS   = 250,
    parameter int P3_MS   = 125,
    parameter int CONV_MS = 26
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] rate_sel,
    input  logic       tick,
    output logic       expired
);
    localparam int D0   = P0_MS - CONV_MS;
    localparam int D1   = P1_MS - CONV_MS;
    localparam int D2   = P2_MS - CONV_MS;
    localparam int D3   = P3_MS - CONV_MS;
    localparam int DM01 = (D0 > D1) ? D0 : D1;
    localparam int DM23 = (D2 > D3) ? D2 : D3;
    localparam int DMAX = (DM01 > DM23) ? DM01 : DM23;
    localparam int CNT_W = $clog2(DMAX + 1);

    logic [CNT_W-1:0] cnt_q;

    // Map a rate code to its sleep length in ticks.
    function automatic logic [CNT_W-1:0] dly_of(input logic [1:0] r);
        case (r)
            2'b00:   dly_of = CNT_W'(D0);
            2'b01:   dly_of = CNT_W'(D1);
            2'b10:   dly_of = CNT_W'(D2);
            default: dly_of = CNT_W'(D3);
        endcase
    endfunction

    // Load on a new sleep, otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= dly_of(rate_sel);
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DMAX));
endmodule

// File: rtl/tsq_result_reg.sv
// Temperature result register. Captures the converter output on an
// accepted done pulse; reads zero from reset until the first capture.
module tsq_result_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // Hold the latest accepted result.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (capture) dout <= din;
    end
endmodule

// File: rtl/tsq_conv_sequencer.sv
// Top of the conversion sequencer. A four-phase controller (idle, launch,
// converting, sleeping) issues start pulses, waits for done, loads the
// result and times the sleep of the repeating loop. Mode changes never
// abort a conversion. Assumes the converter answers every start with
// exactly one done pulse, and ms_tick is a one-cycle pulse.
module tsq_conv_sequencer
    import tsq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int P0_MS   = 4000,
    parameter int P1_MS   = 1000,
    parameter int P2_MS   = 250,
    parameter int P3_MS   = 125,
    parameter int CONV_MS = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_rate,
    output logic [1:0]        mode_rd,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    output logic [DATA_W-1:0] temp_q
);
    tsq_phase_e phase_q, phase_d;
    logic [1:0] mode_q, mode_d, rate_q;
    logic       conv_end, sleep_load, sleep_over;

    assign conv_end   = (phase_q == PH_CONV) && conv_done;
    assign sleep_load = conv_end && mode_d[1];

    tsq_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_mode  (cfg_mode),
        .wr_rate  (cfg_rate),
        .idle_now (phase_q == PH_IDLE),
        .conv_end (conv_end),
        .mode_q   (mode_q),
        .mode_d   (mode_d),
        .rate_q   (rate_q)
    );

    tsq_sleep_timer #(
        .P0_MS   (P0_MS),
        .P1_MS   (P1_MS),
        .P2_MS   (P2_MS),
        .P3_MS   (P3_MS),
        .CONV_MS (CONV_MS)
    ) u_sleep (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sleep_load),
        .rate_sel (rate_q),
        .tick     (ms_tick),
        .expired  (sleep_over)
    );

    tsq_result_reg #(.DATA_W(DATA_W)) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (conv_end),
        .din     (conv_result),
        .dout    (temp_q)
    );

    // Phase transitions of the sequencer.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:   if (mode_d != MODE_OFF) phase_d = PH_LAUNCH;
            PH_LAUNCH: phase_d = PH_CONV;
            PH_CONV:   if (conv_done) phase_d = mode_d[1] ? PH_SLEEP : PH_IDLE;
            PH_SLEEP: begin
                if (mode_d == MODE_OFF) phase_d = PH_IDLE;
                else if (sleep_over)    phase_d = PH_LAUNCH;
            end
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register; reset lands in idle with the loop mode set, so the
    // first conversion launches straight after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign conv_start = (phase_q == PH_LAUNCH);
    assign mode_rd    = mode_q;

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CONV && !conv_done) |=> (phase_q == PH_CONV && !conv_start));

    p_temp_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_q == PH_CONV && conv_done) |=> $stable(temp_q));

    p_shutdown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && mode_q == MODE_OFF && !(cfg_wr && cfg_mode != MODE_OFF))
        |=> !conv_start);
endmodule

// File: tb/tsq_conv_sequencer_tb.sv
// Bench: behavioural reference model compared every clock, plus directed
// scenarios with their own checks.
module tsq_conv_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [1:0] cfg_rate = 2'b00;
    logic [1:0] mode_rd;
    logic       conv_start;
    logic       conv_done = 1'b0;
    logic [7:0] conv_result = 8'h00;
    logic [7:0] temp_q;

    int  n_dir = 0, f_dir = 0, n_cyc = 0, f_cyc = 0, wd_fail = 0, cyc = 0;
    bit  slow_tick = 1'b0;
    bit  done_all = 1'b0;

    int m_mode, m_rate, m_temp, m_ph, m_left, m_nm;

    always #2 clk = ~clk;

    tsq_conv_sequencer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ms_tick     (ms_tick),
        .cfg_wr      (cfg_wr),
        .cfg_mode    (cfg_mode),
        .cfg_rate    (cfg_rate),
        .mode_rd     (mode_rd),
        .conv_start  (conv_start),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .temp_q      (temp_q)
    );

    function automatic int delay_of(input int r);
        case (r)
            0:       return 4000 - 26;
            1:       return 1000 - 26;
            2:       return 250 - 26;
            default: return 125 - 26;
        endcase
    endfunction

    // Reference model: phases 0 idle, 1 start, 2 converting, 3 sleeping.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 2; m_rate = 0; m_temp = 0; m_ph = 0; m_left = 0;
        end else begin
            m_nm = m_mode;
            if (cfg_wr) begin
                if (cfg_mode == 2'b01) begin
                    if (m_mode == 0 && m_ph == 0) m_nm = 1;
                end else m_nm = int'(cfg_mode);
            end
            case (m_ph)
                0: if (m_nm != 0) m_ph = 1;
                1: m_ph = 2;
                2: if (conv_done) begin
                       m_temp = int'(conv_result);
                       if (m_nm == 1) m_nm = 0;
                       if (m_nm >= 2) begin m_ph = 3; m_left = delay_of(m_rate); end
                       else m_ph = 0;
                   end
                default: begin
                    if (m_nm == 0) m_ph = 0;
                    else if (m_left == 0) m_ph = 1;
                    else if (ms_tick) m_left = m_left - 1;
                end
            endcase
            m_mode = m_nm;
            if (cfg_wr) m_rate = int'(cfg_rate);
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_cyc = n_cyc + 3;
            if (int'(conv_start) != (m_ph == 1 ? 1 : 0)) begin
                f_cyc++; $display("FAIL R2 model start act=%0d exp=%0d", conv_start, m_ph == 1);
            end
            if (int'(mode_rd) != m_mode) begin
                f_cyc++; $display("FAIL R6 model mode act=%0d exp=%0d", mode_rd, m_mode);
            end
            if (int'(temp_q) != m_temp) begin
                f_cyc++; $display("FAIL R3 model temp act=%0h exp=%0h", temp_q, m_temp);
            end
        end
    end

    // Tick source: every cycle, or every other cycle when slowed.
    always @(negedge clk) ms_tick <= slow_tick ? ~ms_tick : 1'b1;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_dir + n_cyc + wd_fail, f_dir + f_cyc + wd_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_all) begin
            wd_fail = 1;
            $display("FAIL watchdog act=%0d exp<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_dir++;
        if (act != exp) begin
            f_dir++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic wr(input logic [1:0] m, input logic [1:0] r);
        cfg_wr = 1'b1; cfg_mode = m; cfg_rate = r;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic done_now(input logic [7:0] d);
        conv_done = 1'b1; conv_result = d;
        step();
        conv_done = 1'b0;
    endtask

    // Called on the cycle conv_start is seen: let the phase move, then finish.
    task automatic finish_conv(input logic [7:0] d);
        step();
        done_now(d);
    endtask

    task automatic wait_start(output int c);
        c = 0;
        do begin step(); c++; end while (!conv_start && c < 9000);
    endtask

    task automatic quiet(input string tag, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin step(); if (conv_start) seen++; end
        chk(tag, seen, 0);
    endtask

    initial begin
        int c;
        repeat (3) step();
        chk("R1 reset temp", int'(temp_q), 0);
        chk("R1 reset mode", int'(mode_rd), 2);
        chk("R1 no start in reset", int'(conv_start), 0);
        rst_n = 1'b1;
        step();
        chk("R1 start after reset", int'(conv_start), 1);
        step();
        chk("R2 start one cycle", int'(conv_start), 0);
        repeat (5) step();
        chk("R2 no start while pending", int'(conv_start), 0);
        done_now(8'h19);
        chk("R3 result loaded", int'(temp_q), 8'h19);
        wait_start(c);
        chk("R4 rate 00 interval", c, delay_of(0) + 1);

        finish_conv(8'h32);
        wr(2'b10, 2'b11);
        wait_start(c);
        chk("R5 rate write keeps current sleep", c + 1, delay_of(0) + 1);
        finish_conv(8'h4B);
        wait_start(c);
        chk("R4 rate 11 interval", c, delay_of(3) + 1);
        wr(2'b10, 2'b01);
        finish_conv(8'h50);
        wait_start(c);
        chk("R4 rate 01 interval", c, delay_of(1) + 1);
        wr(2'b10, 2'b10);
        finish_conv(8'h64);
        wait_start(c);
        chk("R4 rate 10 interval", c, delay_of(2) + 1);

        step();
        wr(2'b00, 2'b11);
        chk("R8 mode reads off at once", int'(mode_rd), 0);
        done_now(8'hE7);
        chk("R8 result still loaded", int'(temp_q), 8'hE7);
        quiet("R8 no start after shutdown", 300);
        done_now(8'h55);
        chk("R3 stray done ignored", int'(temp_q), 8'hE7);

        wr(2'b01, 2'b11);
        chk("R6 single starts", int'(conv_start), 1);
        chk("R6 mode reads single", int'(mode_rd), 1);
        wr(2'b01, 2'b11);
        chk("R7 repeat single ignored", int'(mode_rd), 1);
        chk("R7 no extra start", int'(conv_start), 0);
        done_now(8'hC9);
        chk("R6 mode reverts", int'(mode_rd), 0);
        chk("R6 result", int'(temp_q), 8'hC9);
        quiet("R6 no further start", 200);

        wr(2'b10, 2'b11);
        chk("R9 loop write starts at once", int'(conv_start), 1);
        finish_conv(8'h7F);
        wr(2'b01, 2'b11);
        chk("R7 single ignored while looping", int'(mode_rd), 2);
        wr(2'b00, 2'b11);
        chk("R9 mode off in sleep", int'(mode_rd), 0);
        quiet("R9 no start after sleep shutdown", 300);

        wr(2'b01, 2'b11);
        chk("R6 single start again", int'(conv_start), 1);
        wr(2'b11, 2'b11);
        done_now(8'hFF);
        chk("R10 mode kept as loop", int'(mode_rd), 3);
        chk("R10 result", int'(temp_q), 8'hFF);
        wait_start(c);
        chk("R10 sleep follows", c, delay_of(3) + 1);

        slow_tick = 1'b1;
        finish_conv(8'h00);
        wait_start(c);
        n_dir++;
        if (c < 2 * delay_of(3) || c > 2 * delay_of(3) + 3) begin
            f_dir++;
            $display("FAIL R4 sparse ticks act=%0d exp=%0d..%0d", c, 2 * delay_of(3), 2 * delay_of(3) + 3);
        end
        slow_tick = 1'b0;
        repeat (4) step();

        done_all = 1'b1;
        summary();
        $finish;
    end
endmodule